// File: doc/BRIEF.md
# Slow-Tick Down-Counting Timer

This block is a programmable down-counter that advances on a slow, always-on time base while software programs it from the fast bus clock. The slow time base is modelled as a one-cycle enable, `TICK_DIV` bus cycles apart, generated inside the block. Software writes a reload value and a control word. The control bits pass through a two-stage synchronizer before the counting logic acts on them, so a start command takes effect only at the first slow tick after synchronization. Until that tick, the count register reads zero while the start bit already reads one. Software can use this pairing to tell that a start is still in flight.

On each slow tick the count drops by one. The tick on which the count is at one or zero is the terminal tick. It produces a one-cycle interrupt pulse. With auto-reload on, the counter reloads from the reload register and keeps running. Without it, the block clears its own start bit and stops. Counting can be frozen in two ways: by a halt bit, or by an external debug-halt input when the debug-freeze enable bit is set.

The control flow is a five-state machine:
- `ST_OFF`: idle.
- `ST_SYNC`: a start was written and is waiting for the synchronizer.
- `ST_LOAD`: the start has arrived and the block is waiting for the slow tick that loads the count.
- `ST_RUN`: counting.
- `ST_HOLD`: frozen by a halt condition.

The named transitions are:
- arm (any state to `ST_SYNC`, when a start bit is written from 0 to 1)
- sync-abort (`ST_SYNC` to `ST_OFF`, when the start bit is cleared on the bus side)
- sync-done (`ST_SYNC` to `ST_LOAD`, or to `ST_OFF` if the block is not activated)
- load (`ST_LOAD` to `ST_RUN` on a tick)
- freeze (`ST_RUN` to `ST_HOLD`)
- thaw (`ST_HOLD` to `ST_RUN`)
- expire (`ST_RUN` to `ST_OFF` on a one-shot terminal tick)
- kill (`ST_LOAD`, `ST_RUN` or `ST_HOLD` to `ST_OFF` when the synchronized activate or start bit is low)

Top module: `slow_tick_timer`

## Requirements
- R1: After reset, the count, reload and control registers all read 0, and `irq_o` is low.
- R2: `reg_idx` selects the word: 0 is the count (read-only, writes ignored), 1 is the reload value, 2 is the control word. The control bits are: bit 0 activate, bit 1 auto-reload, bit 2 start, bit 3 debug-freeze enable, bit 4 halt. Control bits 31..5 read as 0.
- R3: Writing the start bit from 0 to 1 makes the count read 0 while control reads start=1. This lasts until the load. The load puts the reload value into the count no sooner than 3 and no later than `TICK_DIV`+3 bus cycles after the write.
- R4: While running, the count drops by exactly one every `TICK_DIV` bus cycles and changes at no other time, except on a load or a reload.
- R5: A reload-register write while running leaves the current count alone. The new value is used at the next terminal tick.
- R6: A terminal tick (count at 1 or 0) produces `irq_o` high for exactly one bus cycle, in the cycle after the tick.
- R7: With auto-reload set, the count reloads at each terminal tick. Interrupts then repeat every max(P,1)×`TICK_DIV` bus cycles, where P is the reload value.
- R8: With auto-reload clear, a terminal tick leaves the count at 0, clears the start bit, and no further interrupt follows.
- R9: While the halt bit is 1, the count is frozen. Clearing the halt bit resumes counting.
- R10: With the debug-freeze enable set, a high `dbg_halt_i` freezes the count. With the enable clear, `dbg_halt_i` has no effect.
- R11: Writing 0 to the control word stops the timer. The count then stays constant, no interrupt follows, and control reads 0.
- R12: Starting with activate clear never loads or counts. The count stays 0 and no interrupt is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt_i | input | 1 | External debug-halt request |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the word at `reg_idx` (combinational) |
| irq_o | output | 1 | One-cycle terminal-count interrupt pulse |

## Verification
The bench builds the block with `TICK_DIV` = 6 and the default 32-bit count. The short tick spacing lets many full auto-reload periods, including reload values of 0 and 1, fit in a short run. It also makes the start-latency bound of `TICK_DIV`+3 cycles tight enough that a load arriving one tick late is caught. Random reload values of up to 12 keep each interrupt interval small, so every interval can be compared exactly against max(P,1)×6 cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 32;
    localparam int CTL_W  = 5;

    localparam logic [1:0] IDX_COUNT   = 2'd0;
    localparam logic [1:0] IDX_RELOAD  = 2'd1;
    localparam logic [1:0] IDX_CONTROL = 2'd2;

    localparam int CB_ACT  = 0;
    localparam int CB_ARL  = 1;
    localparam int CB_GO   = 2;
    localparam int CB_DBGEN = 3;
    localparam int CB_HALT = 4;

    typedef struct packed {
        logic halt;
        logic dbg_en;
        logic go;
        logic arl;
        logic act;
    } tmr_ctrl_t;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_SYNC = 3'd1,
        ST_LOAD = 3'd2,
        ST_RUN  = 3'd3,
        ST_HOLD = 3'd4
    } tmr_state_e;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int TICK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              clr_go,
    output tmr_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              arm
);
    logic ctl_wr;
    logic rel_wr;

    assign ctl_wr = reg_we && (reg_idx == IDX_CONTROL);
    assign rel_wr = reg_we && (reg_idx == IDX_RELOAD);

    // start request: bus-side 0 -> 1 of the go bit
    assign arm = ctl_wr && reg_wdata[CB_GO] && !ctrl.go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctl_wr) begin
            ctrl <= tmr_ctrl_t'(reg_wdata[CTL_W-1:0]);
        end else if (clr_go) begin
            ctrl.go <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (rel_wr) begin
            reload <= reg_wdata[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic             bus_go,
    input  logic             s_act,
    input  logic             s_arl,
    input  logic             s_go,
    input  logic             s_dbgen,
    input  logic             s_halt,
    input  logic             s_dbg,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             clr_go,
    output tmr_state_e       state
);
    tmr_state_e state_q;
    tmr_state_e state_d;
    logic       go_d_q;
    logic       go_rise;
    logic       live;
    logic       hold_c;
    logic       term;
    logic       fire;
    logic       do_load;

    assign go_rise = s_go && !go_d_q;
    assign live    = s_act && s_go;
    assign hold_c  = s_halt || (s_dbgen && s_dbg);
    assign term    = (count <= CNT_W'(1));
    assign do_load = !arm && (state_q == ST_LOAD) && live && tick;
    assign fire    = !arm && (state_q == ST_RUN) && live && !hold_c && tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            go_d_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            go_d_q  <= s_go;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (arm) begin
            state_d = ST_SYNC;                       // arm
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_OFF;
                ST_SYNC: begin
                    if (!bus_go)      state_d = ST_OFF;  // sync-abort
                    else if (go_rise) state_d = s_act ? ST_LOAD : ST_OFF; // sync-done
                end
                ST_LOAD: begin
                    if (!live)        state_d = ST_OFF;  // kill
                    else if (tick)    state_d = ST_RUN;  // load
                end
                ST_RUN: begin
                    if (!live)        state_d = ST_OFF;  // kill
                    else if (hold_c)  state_d = ST_HOLD; // freeze
                    else if (tick && term && !s_arl) state_d = ST_OFF; // expire
                end
                ST_HOLD: begin
                    if (!live)        state_d = ST_OFF;  // kill
                    else if (!hold_c) state_d = ST_RUN;  // thaw
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (arm) begin
            count <= '0;
        end else if (do_load) begin
            count <= reload;
        end else if (fire) begin
            if (term) count <= s_arl ? reload : '0;
            else      count <= count - CNT_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire && term;
    end

    assign clr_go = fire && term && !s_arl;
    assign state  = state_q;
endmodule

// File: rtl/slow_tick_timer.sv
module slow_tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int TICK_DIV = 8,
    parameter int SYNC_N   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_halt_i,
    input  logic        reg_we,
    input  logic [1:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o
);
    localparam int SW = CTL_W + 1;

    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             arm;
    logic             tick;
    logic             clr_go;
    logic [SW-1:0]    sync_d;
    logic [SW-1:0]    sync_q;
    tmr_state_e       core_state;

    tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_idx  (reg_idx),
        .reg_wdata(reg_wdata),
        .clr_go   (clr_go),
        .ctrl     (ctrl),
        .reload   (reload),
        .arm      (arm)
    );

    assign sync_d = {dbg_halt_i, ctrl.halt, ctrl.dbg_en, ctrl.go, ctrl.arl, ctrl.act};

    tmr_sync #(.W(SW), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sync_d),
        .q    (sync_q)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .arm    (arm),
        .bus_go (ctrl.go),
        .s_act  (sync_q[0]),
        .s_arl  (sync_q[1]),
        .s_go   (sync_q[2]),
        .s_dbgen(sync_q[3]),
        .s_halt (sync_q[4]),
        .s_dbg  (sync_q[5]),
        .reload (reload),
        .count  (count),
        .irq    (irq_o),
        .clr_go (clr_go),
        .state  (core_state)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_COUNT:   reg_rdata = DATA_W'(count);
            IDX_RELOAD:  reg_rdata = DATA_W'(reload);
            IDX_CONTROL: reg_rdata = DATA_W'(ctrl);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             arm,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input tmr_state_e       state,
    input logic             reg_we,
    input logic [1:0]       reg_idx,
    input logic [4:0]       ctl_wdata
);
    // R6: interrupt lasts one cycle
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: interrupt follows a slow tick
    assert_irq_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));

    // R4: count moves only on a tick or a start request
    assert_count_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !arm) |=> $stable(count));

    // R9: frozen while held
    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !arm) |=> $stable(count));

    // R11: control cleared reaches the off state after synchronization
    assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == IDX_CONTROL && ctl_wdata == 5'd0)
            |=> ##3 (state == ST_OFF || state == ST_SYNC));
endmodule

bind slow_tick_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .arm      (arm),
    .irq      (irq_o),
    .count    (count),
    .state    (core_state),
    .reg_we   (reg_we),
    .reg_idx  (reg_idx),
    .ctl_wdata(reg_wdata[4:0])
);

// File: tb/sim_slow_tick_timer.sv
module sim_slow_tick_timer;
    localparam int DIV   = 6;
    localparam int LIMIT = 150000;
    localparam logic [31:0] C_ACT = 32'h1, C_ARL = 32'h2, C_GO = 32'h4,
                            C_DBG = 32'h8, C_HALT = 32'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_halt_i = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0, errors = 0;
    int cyc = 0, irq_cnt = 0, last_int = 0, prev_t = 0, pulse_err = 0;
    logic irq_prev = 1'b0;

    always #4 clk = ~clk;

    slow_tick_timer #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .dbg_halt_i(dbg_halt_i), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic int exp_interval(int p);
        return ((p < 1) ? 1 : p) * DIV;
    endfunction

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        irq_prev <= irq_o;
        if (irq_o && irq_prev) pulse_err <= pulse_err + 1;
        if (irq_o) begin
            last_int <= cyc - prev_t;
            prev_t   <= cyc;
            irq_cnt  <= irq_cnt + 1;
        end
        if (cyc == LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog all-reqs act=%0d exp=<%0d", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output int v);
        reg_idx = idx;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq();
        int base;
        base = irq_cnt;
        while (irq_cnt == base) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int v, v2, n, base, p;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, v); check(v == 0, "R1 count", v, 0);
        rd(2'd1, v); check(v == 0, "R1 reload", v, 0);
        rd(2'd2, v); check(v == 0, "R1 control", v, 0);
        check(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);

        // R2 count is read-only, unused control bits read 0
        wr(2'd0, 32'h55); rd(2'd0, v); check(v == 0, "R2 count write ignored", v, 0);
        wr(2'd2, 32'hFFFF_FFE0); rd(2'd2, v); check(v == 0, "R2 control upper bits", v, 0);

        // R3 load latency window, one-shot
        wr(2'd1, 32'd10);
        wr(2'd2, C_ACT | C_GO);
        rd(2'd0, v); check(v == 0, "R3 count zero in window", v, 0);
        rd(2'd2, v); check(v == 5, "R3 start reads one", v, 5);
        n = 0;
        while (v != 10 && n < 40) begin
            @(negedge clk); n++; rd(2'd0, v);
            if (v != 0 && v != 10) n = 99;
        end
        check(v == 10, "R3 loaded value", v, 10);
        check(n >= 3 && n <= DIV + 3, "R3 load latency", n, DIV + 3);

        // R4 one step per tick
        idle(DIV); rd(2'd0, v); check(v == 9, "R4 first step", v, 9);
        idle(5 * DIV); rd(2'd0, v); check(v == 4, "R4 five more", v, 4);

        // R8 one-shot end
        wait_irq();
        idle(2);
        rd(2'd2, v); check(v == 1, "R8 start cleared", v, 1);
        rd(2'd0, v); check(v == 0, "R8 count at zero", v, 0);
        base = irq_cnt; idle(40 * DIV);
        check(irq_cnt == base, "R8 no further irq", irq_cnt, base);

        // R7 auto-reload, random reload values including 0 and 1
        for (int k = 0; k < 8; k++) begin
            p = (k == 0) ? 0 : (k == 1) ? 1 : int'($urandom_range(2, 12));
            wr(2'd2, 32'd0); idle(4);
            wr(2'd1, p);
            wr(2'd2, C_ACT | C_ARL | C_GO);
            wait_irq();
            for (int j = 0; j < 2; j++) begin
                wait_irq();
                check(last_int == exp_interval(p), "R7 period", last_int, exp_interval(p));
            end
        end

        // R5 deferred reload
        wr(2'd2, 32'd0); idle(4);
        wr(2'd1, 32'd20);
        wr(2'd2, C_ACT | C_ARL | C_GO);
        wait_irq();
        idle(3 * DIV);
        rd(2'd0, v);
        wr(2'd1, 32'd5);
        rd(2'd0, v2);
        check(v2 <= v && v2 >= v - 1, "R5 count undisturbed", v2, v);
        wait_irq();
        check(last_int == 20 * DIV, "R5 old value this period", last_int, 20 * DIV);
        wait_irq();
        check(last_int == 5 * DIV, "R5 new value next period", last_int, 5 * DIV);

        // R6 pulse width
        check(pulse_err == 0, "R6 single-cycle irq", pulse_err, 0);

        // R9 halt bit
        wr(2'd1, 32'd50);
        wr(2'd2, C_ACT | C_ARL | C_GO | C_HALT);
        idle(4); rd(2'd0, v);
        idle(5 * DIV); rd(2'd0, v2);
        check(v2 == v, "R9 frozen by halt", v2, v);
        wr(2'd2, C_ACT | C_ARL | C_GO);
        idle(3 + 2 * DIV); rd(2'd0, v2);
        check(v2 != v, "R9 resumes", v2, v);

        // R10 debug halt
        wr(2'd2, C_ACT | C_ARL | C_GO | C_DBG);
        dbg_halt_i = 1'b1;
        idle(4); rd(2'd0, v);
        idle(5 * DIV); rd(2'd0, v2);
        check(v2 == v, "R10 frozen by debug halt", v2, v);
        wr(2'd2, C_ACT | C_ARL | C_GO);
        idle(4); rd(2'd0, v);
        idle(2 * DIV); rd(2'd0, v2);
        check(v2 != v, "R10 input ignored without enable", v2, v);
        dbg_halt_i = 1'b0;

        // R11 stop by writing zero
        wr(2'd2, 32'd0);
        idle(4); rd(2'd0, v); base = irq_cnt;
        idle(60 * DIV); rd(2'd0, v2);
        check(v2 == v, "R11 count stays", v2, v);
        check(irq_cnt == base, "R11 no irq", irq_cnt, base);
        rd(2'd2, v); check(v == 0, "R11 control reads 0", v, 0);

        // R12 start without activate
        wr(2'd1, 32'd7);
        wr(2'd2, C_GO);
        base = irq_cnt;
        idle(12 * DIV); rd(2'd0, v);
        check(v == 0, "R12 never loads", v, 0);
        check(irq_cnt == base, "R12 no irq", irq_cnt, base);

        summary();
        $finish;
    end
endmodule